// File: doc/BRIEF.md
# Bus-Cycle Fault Register Capture

This block keeps a 16-bit sticky fault register for a 16-bit processor core. It watches the active-low bus-busy line, whether or not the core owns the bus. When that line returns high, the bus cycle has ended, and the block samples three active-low error inputs at that point. Each asserted error sets one register bit. The bit it sets depends on two facts about the cycle: whether the core or another master owned it, and whether it was a memory or an I/O access.

Two asynchronous system-fault inputs are captured on their rising edges. The second of these sets two register bits together. All asynchronous inputs pass through a synchronizer before any edge is detected.

The core reads the register directly. It clears the register with a one-cycle strobe, and a fault arriving in that same cycle is not lost. Two error outputs summarize the register: one for major faults and one for unrecoverable faults. Each is driven from its own parameterized set of bits.

Top module: `bus_fault_capture`

## Requirements
- R1: While rst_n is low at a clock edge, the register clears to all zeros on that edge, and major_err and unrcv_err are low.
- R2: Register bit n appears on fault_q[15-n], so bit 0 is the MSB. A low prot_err_n at the end of a cycle sets bit 0 when cpu_owns is high and bit 1 when cpu_owns is low.
- R3: A low par_err_n at the end of a cycle sets bit 2, whoever owns the cycle.
- R4: A low addr_err_n at the end of a cycle sets bit 5 when mem_cycle is high (memory) and bit 8 when mem_cycle is low (I/O).
- R5: Error inputs are sampled only when bus_busy_n goes from low to high. Error levels present while bus_busy_n stays high, or withdrawn before it rises, set nothing.
- R6: A rising edge on sysflt0 sets bit 7. A level held high does not set the bit again after a clear; only a new rising edge does.
- R7: A rising edge on sysflt1 sets bit 13 and bit 15 in the same cycle.
- R8: Set bits stay set until rd_clr is sampled high. The clear takes effect on the next edge, and a bit being set in that same cycle survives the clear.
- R9: major_err is high when any of bits 0, 1, 5, 7 or 8 is set. unrcv_err is high when any of bits 2, 13 or 15 is set. These are the default masks.
- R10: With the default two-stage synchronizer, a change on bus_busy_n or on a system-fault input shows in fault_q after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_busy_n | input | 1 | Active-low bus-busy line; its low-to-high transition ends a cycle |
| cpu_owns | input | 1 | High when the current cycle belongs to this core |
| mem_cycle | input | 1 | High for a memory cycle, low for an I/O cycle |
| prot_err_n | input | 1 | Active-low memory-protect error |
| par_err_n | input | 1 | Active-low memory-parity error |
| addr_err_n | input | 1 | Active-low external-address error |
| sysflt0 | input | 1 | Asynchronous system fault 0, rising-edge active |
| sysflt1 | input | 1 | Asynchronous system fault 1, rising-edge active |
| rd_clr | input | 1 | Core strobe that clears the register |
| fault_q | output | 16 | Fault register, register bit n on fault_q[15-n] |
| major_err | output | 1 | Any major-class bit set |
| unrcv_err | output | 1 | Any unrecoverable-class bit set |

## Verification
The bench sweeps every combination of ownership, cycle type and the three error inputs. If the ownership or memory/I-O steering were swapped, the wrong bit would light, and the bit-numbering check would catch an LSB-first layout.

It tests errors shown outside a cycle end, and errors withdrawn before the end. A design sampling on the wrong busy edge or on a level would set bits there.

It holds a system fault high across a clear. A level-triggered capture would set the bit again.

It also lines up a clear with a fresh capture. A clear-wins priority would lose that fault. Finally, it samples one cycle before and at the expected latency, which exposes a missing or extra synchronizer stage.

// File: rtl/bfc_pkg.sv
// Shared constants and helpers for the bus-cycle fault register.
// Register bit numbering puts bit 0 at the MSB of the vector.
package bfc_pkg;
    localparam int FR_W        = 16;
    localparam int B_PROT_CPU  = 0;
    localparam int B_PROT_EXT  = 1;
    localparam int B_PARITY    = 2;
    localparam int B_ADDR_MEM  = 5;
    localparam int B_SYS0      = 7;
    localparam int B_ADDR_IO   = 8;
    localparam int B_SYS1_A    = 13;
    localparam int B_SYS1_B    = 15;

    typedef logic [FR_W-1:0] fault_vec_t;

    // Vector with only register bit n set (bit 0 is the MSB).
    function automatic fault_vec_t bit_of(input int n);
        fault_vec_t v;
        v = '0;
        v[FR_W-1-n] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/bfc_sync.sv
// Multi-stage synchronizer bank for asynchronous inputs.
// Assumes STAGES >= 2; every stage resets to RST_VAL so that
// idle levels produce no edge when reset is released.
module bfc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bfc_edge.sv
// Rising-edge detector for already synchronized signals.
// The history register resets high, so a signal that is high out of
// reset is not reported as a new edge.
module bfc_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    // Remember last cycle's levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/bfc_route.sv
// Fixed routing of sampled faults into register set bits.
// Bus errors count only in the cycle where the end of a bus cycle is
// detected; system faults count on their own rising edges.
module bfc_route
    import bfc_pkg::*;
(
    input  logic       cyc_end,
    input  logic       own,
    input  logic       mem,
    input  logic       prot_n,
    input  logic       par_n,
    input  logic       addr_n,
    input  logic [1:0] sf_rise,
    output fault_vec_t set_vec
);
    // Build the set mask for this cycle.
    always_comb begin
        set_vec = '0;
        if (cyc_end) begin
            if (!prot_n) begin
                set_vec = set_vec | (own ? bit_of(B_PROT_CPU) : bit_of(B_PROT_EXT));
            end
            if (!par_n) begin
                set_vec = set_vec | bit_of(B_PARITY);
            end
            if (!addr_n) begin
                set_vec = set_vec | (mem ? bit_of(B_ADDR_MEM) : bit_of(B_ADDR_IO));
            end
        end
        if (sf_rise[0]) begin
            set_vec = set_vec | bit_of(B_SYS0);
        end
        if (sf_rise[1]) begin
            set_vec = set_vec | bit_of(B_SYS1_A) | bit_of(B_SYS1_B);
        end
    end
endmodule

// File: rtl/bus_fault_capture.sv
// Bus-cycle fault register: synchronizes bus-busy, cycle qualifiers,
// error lines and system faults; captures faults at the end of each
// bus cycle (busy low-to-high) into sticky bits; clears on rd_clr with
// new captures taking priority. Masks are in fault_q orientation.
module bus_fault_capture
    import bfc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter fault_vec_t MAJOR_MASK  = 16'hC580,
    parameter fault_vec_t UNRCV_MASK  = 16'h2005
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_busy_n,
    input  logic            cpu_owns,
    input  logic            mem_cycle,
    input  logic            prot_err_n,
    input  logic            par_err_n,
    input  logic            addr_err_n,
    input  logic            sysflt0,
    input  logic            sysflt1,
    input  logic            rd_clr,
    output logic [FR_W-1:0] fault_q,
    output logic            major_err,
    output logic            unrcv_err
);
    localparam int NSYNC = 8;
    localparam int NEDGE = 3;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    logic [NEDGE-1:0] edge_rise;
    fault_vec_t       set_vec;
    fault_vec_t       fault_r;

    assign raw_in = {sysflt1, sysflt0, addr_err_n, par_err_n,
                     prot_err_n, mem_cycle, cpu_owns, bus_busy_n};

    bfc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL({NSYNC{1'b1}})) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn)
    );

    bfc_edge #(.W(NEDGE)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({syn[7], syn[6], syn[0]}),
        .rise (edge_rise)
    );

    bfc_route u_route (
        .cyc_end(edge_rise[0]),
        .own    (syn[1]),
        .mem    (syn[2]),
        .prot_n (syn[3]),
        .par_n  (syn[4]),
        .addr_n (syn[5]),
        .sf_rise(edge_rise[2:1]),
        .set_vec(set_vec)
    );

    // Sticky fault register; a capture in the clear cycle survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_r <= '0;
        end else if (rd_clr) begin
            fault_r <= set_vec;
        end else begin
            fault_r <= fault_r | set_vec;
        end
    end

    assign fault_q   = fault_r;
    assign major_err = |(fault_r & MAJOR_MASK);
    assign unrcv_err = |(fault_r & UNRCV_MASK);
endmodule

// File: rtl/bfc_checker.sv
// Property checker for bus_fault_capture, attached by bind.
module bfc_checker
    import bfc_pkg::*;
#(
    parameter fault_vec_t MAJOR_MASK = 16'hC580,
    parameter fault_vec_t UNRCV_MASK = 16'h2005
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_clr,
    input fault_vec_t fault_q,
    input fault_vec_t set_vec,
    input logic       major_err,
    input logic       unrcv_err
);
    // R1: reset empties the register.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (fault_q == '0));

    // R8: bits persist while no clear is requested.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

    // R8: a clear keeps exactly the bits captured in that cycle.
    a_r8_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (fault_q == $past(set_vec)));

    // R10: captured bits appear one edge after routing.
    a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((fault_q & $past(set_vec)) == $past(set_vec)));

    // R5: no bit appears without a capture.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((fault_q & ~$past(fault_q) & ~$past(set_vec)) == '0));

    // R7: the two bits of system fault 1 move together.
    a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q[FR_W-1-B_SYS1_A] == fault_q[FR_W-1-B_SYS1_B]);

    // R2: one protect error lands in exactly one of its two bits.
    a_r2_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_vec[FR_W-1-B_PROT_CPU], set_vec[FR_W-1-B_PROT_EXT]}));

    // R4: one address error lands in exactly one of its two bits.
    a_r4_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_vec[FR_W-1-B_ADDR_MEM], set_vec[FR_W-1-B_ADDR_IO]}));

    // R9: summary outputs rise only after a capture of their class.
    a_r9_major_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(major_err) |-> (($past(set_vec) & MAJOR_MASK) != '0));

    a_r9_unrcv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unrcv_err) |-> (($past(set_vec) & UNRCV_MASK) != '0));
endmodule

bind bus_fault_capture bfc_checker #(
    .MAJOR_MASK(MAJOR_MASK),
    .UNRCV_MASK(UNRCV_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_clr   (rd_clr),
    .fault_q  (fault_q),
    .set_vec  (set_vec),
    .major_err(major_err),
    .unrcv_err(unrcv_err)
);

// File: tb/sim_bus_fault_capture.sv
`timescale 1ns/1ps
module sim_bus_fault_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_busy_n = 1'b1;
    logic        cpu_owns = 1'b0;
    logic        mem_cycle = 1'b0;
    logic        prot_err_n = 1'b1;
    logic        par_err_n = 1'b1;
    logic        addr_err_n = 1'b1;
    logic        sysflt0 = 1'b0;
    logic        sysflt1 = 1'b0;
    logic        rd_clr = 1'b0;
    logic [15:0] fault_q;
    logic        major_err;
    logic        unrcv_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bus_fault_capture u0 (
        .clk(clk), .rst_n(rst_n), .bus_busy_n(bus_busy_n),
        .cpu_owns(cpu_owns), .mem_cycle(mem_cycle),
        .prot_err_n(prot_err_n), .par_err_n(par_err_n),
        .addr_err_n(addr_err_n), .sysflt0(sysflt0), .sysflt1(sysflt1),
        .rd_clr(rd_clr), .fault_q(fault_q),
        .major_err(major_err), .unrcv_err(unrcv_err)
    );

    function automatic logic [15:0] rb(input int n);
        return 16'h1 << (15 - n);
    endfunction

    function automatic logic [15:0] major_set();
        return rb(0) | rb(1) | rb(5) | rb(7) | rb(8);
    endfunction

    function automatic logic [15:0] unrcv_set();
        return rb(2) | rb(13) | rb(15);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [15:0] exp);
        check({tag, " fault_q"}, fault_q, exp);
        check({"R9 major ", tag}, {15'd0, major_err}, {15'd0, |(exp & major_set())});
        check({"R9 unrcv ", tag}, {15'd0, unrcv_err}, {15'd0, |(exp & unrcv_set())});
    endtask

    task automatic clear_all();
        rd_clr = 1'b1;
        tick(1);
        rd_clr = 1'b0;
    endtask

    task automatic bus_cycle(input logic own, input logic mem, input logic [2:0] e);
        bus_busy_n = 1'b0;
        cpu_owns   = own;
        mem_cycle  = mem;
        prot_err_n = ~e[0];
        par_err_n  = ~e[1];
        addr_err_n = ~e[2];
        tick(3);
        bus_busy_n = 1'b1;
        tick(3);
        prot_err_n = 1'b1;
        par_err_n  = 1'b1;
        addr_err_n = 1'b1;
        tick(3);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] exp;
        tick(4);
        check_all("R1 reset", 16'h0000);
        rst_n = 1'b1;
        tick(2);
        check_all("R1 after release", 16'h0000);

        // Sweep ownership, cycle type and error combinations (R2 R3 R4).
        for (int own = 0; own < 2; own++) begin
            for (int mem = 0; mem < 2; mem++) begin
                for (int e = 0; e < 8; e++) begin
                    clear_all();
                    check("R8 clear", fault_q, 16'h0000);
                    bus_cycle(own[0], mem[0], e[2:0]);
                    exp = '0;
                    if (e[0]) exp |= (own != 0) ? rb(0) : rb(1);
                    if (e[1]) exp |= rb(2);
                    if (e[2]) exp |= (mem != 0) ? rb(5) : rb(8);
                    check_all("R2 R3 R4 sweep", exp);
                end
            end
        end

        // R8: sticky accumulation over cycles.
        clear_all();
        bus_cycle(1'b1, 1'b1, 3'b001);
        bus_cycle(1'b0, 1'b0, 3'b101);
        check_all("R8 accumulate", rb(0) | rb(1) | rb(8));

        // R5: errors without a cycle end, and errors withdrawn early.
        clear_all();
        prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
        tick(6);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        tick(4);
        check_all("R5 idle errors", 16'h0000);
        bus_busy_n = 1'b0;
        prot_err_n = 1'b0; par_err_n = 1'b0; addr_err_n = 1'b0;
        tick(2);
        prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
        tick(3);
        bus_busy_n = 1'b1;
        tick(4);
        check_all("R5 withdrawn errors", 16'h0000);

        // R6 and R10: system fault 0 edge, latency and held level.
        clear_all();
        sysflt0 = 1'b1;
        tick(2);
        check("R10 not yet", fault_q, 16'h0000);
        tick(1);
        check_all("R6 R10 sysflt0 set", rb(7));
        clear_all();
        tick(4);
        check_all("R6 held level", 16'h0000);
        sysflt0 = 1'b0;
        tick(3);
        sysflt0 = 1'b1;
        tick(3);
        check_all("R6 new edge", rb(7));

        // R7: system fault 1 sets two bits.
        clear_all();
        sysflt1 = 1'b1;
        tick(3);
        check_all("R7 sysflt1", rb(13) | rb(15));
        sysflt1 = 1'b0;

        // R8: clear collides with a fresh capture.
        sysflt0 = 1'b0;
        tick(4);
        clear_all();
        bus_cycle(1'b1, 1'b1, 3'b010);
        check_all("R8 before collision", rb(2));
        sysflt0 = 1'b1;
        tick(2);
        rd_clr = 1'b1;
        tick(1);
        rd_clr = 1'b0;
        check_all("R8 collision keeps new", rb(7));

        // R10: bus-cycle latency, one edge early and on time.
        clear_all();
        bus_busy_n = 1'b0; cpu_owns = 1'b0; par_err_n = 1'b0;
        tick(3);
        bus_busy_n = 1'b1;
        tick(2);
        check("R10 busy not yet", fault_q, 16'h0000);
        tick(1);
        check("R10 busy on time", fault_q, rb(2));
        par_err_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule